// File: doc/BRIEF.md
# Relay Command Translator with Base-Address Intercept

This block sits between a command source (a network relay's processor side) and the byte-wide register port of a parallel-bus master controller. Each command carries an operation, an 8-bit low controller address, a data byte and a stream length. The block turns it into a sequence of register accesses on the controller port. The sequence loads the address bytes, the data byte, the address-modifier/direction control byte and the strobe byte. It then polls the status byte until the cycle ends, reads the result back, and clears the strobes.

The upper base-address bytes live inside the block. Byte writes to low addresses 42 to 45 are absorbed: they update those bytes and produce no register-port activity, so no slave sees a stray write while the base address changes. When the upper three base bytes are zero, reads of a few low addresses are answered locally. These are an identity code, a hardware version, a firmware version, and a test portal that streams a byte ramp.

Both sides of the command interface are valid/ready. A command is taken only when the block is fully idle, with no bus sequence running and no response waiting. Every command produces at least one response beat. A response beat stays presented, unchanged, until the requester takes it, and the block accepts nothing new during that time. This is how back-pressure on the response side reaches the command side.

Top module: `relay_cmd_xlate`

## Requirements
- R1: A write command (op code 0) to low address 42, 43, 44 or 45 stores its data in base byte 3, 2, 1 or 0 respectively. It causes no register-port access and returns one beat with data 0x00, both error flags low and last high.
- R2: Any other write drives this register-port sequence: 42←byte3, 43←byte2, 44←byte1, 45←command address, data register, 46←0xA7, 47←strobe, polls of 47, then 47←0x00. Base bytes 3..1 are left unchanged.
- R3: An even command address (bit 0 clear) uses data register 50 and strobe 0x06. An odd address uses data register 51 and strobe 0x05.
- R4: A read (op code 1 or 3) drives the same sequence with no data-register write and with 0x A7 replaced by 0xE7 in register 46. After completion it reads register 50 (even) or 51 (odd) and returns that byte.
- R5: The cycle ends at the first poll of register 47 that reads non-zero. If bit 0 (bus error) is set, the beat returns err=1 and data 0x00. Otherwise bit 1 (acknowledge) ends it normally with err=0.
- R6: If TIMEOUT_CYC consecutive polls read zero, the block writes 0x00 to register 47 and returns a beat with tmo=1, err=0 and data 0x00.
- R7: With base bytes 3, 2 and 1 all zero, reads of address 0, 18 and 19 return 87, HW_VER and FW_VER, with no register-port access.
- R8: With a zero base, a stream read (op code 2) of address 63 returns cmd_len+1 beats carrying 0,1,2,… modulo 256 with no port access. Only the final beat has last=1.
- R9: A stream read of any address not answered locally performs cmd_len+1 full bus reads, one beat each, in order.
- R10: cmd_ready is high only when the block is idle and no beat is pending. A pending beat (rsp_valid high, rsp_ready low) keeps its data and flags unchanged.
- R11: After reset, cmd_ready=1, rsp_valid=0, no port access, and all base bytes are zero, so the identity answers are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 0 write, 1 read, 2 stream read, 3 read |
| cmd_addr | input | 8 | Low controller address |
| cmd_data | input | 8 | Write data byte |
| cmd_len | input | LEN_W | Stream beats minus one |
| rsp_valid | output | 1 | Response beat presented |
| rsp_ready | input | 1 | Requester takes the beat |
| rsp_data | output | 8 | Returned byte |
| rsp_err | output | 1 | Cycle ended by bus error |
| rsp_tmo | output | 1 | Cycle ended by timeout |
| rsp_last | output | 1 | Final beat of the command |
| reg_wr | output | 1 | Controller register write strobe |
| reg_rd | output | 1 | Controller register read strobe |
| reg_addr | output | 6 | Controller register offset |
| reg_wdata | output | 8 | Controller write data |
| reg_rdata | input | 8 | Controller read data, valid in the reg_rd cycle |

## Verification
Two functions can meet in one cycle. One is a response beat held by a requester that is not ready. The other is a new command arriving at the command port. The bench parks a locally answered beat, then offers the next command while the beat is still held. It checks on every following cycle that cmd_ready stays low and that the parked data does not move. It then releases the beat and confirms the waiting command is taken and answered with its own value. The ramp portal is judged the same way: each beat must hold its value while stalled and only advance after a handshake.

// File: rtl/relay_xlate_pkg.sv
package relay_xlate_pkg;
  localparam logic [1:0] OP_WRITE  = 2'd0;
  localparam logic [1:0] OP_READ   = 2'd1;
  localparam logic [1:0] OP_STREAM = 2'd2;

  localparam logic [5:0] RG_ADR3  = 6'd42;
  localparam logic [5:0] RG_ADR2  = 6'd43;
  localparam logic [5:0] RG_ADR1  = 6'd44;
  localparam logic [5:0] RG_ADR0  = 6'd45;
  localparam logic [5:0] RG_MODE  = 6'd46;
  localparam logic [5:0] RG_STRB  = 6'd47;
  localparam logic [5:0] RG_DEVEN = 6'd50;
  localparam logic [5:0] RG_DODD  = 6'd51;

  localparam logic [7:0] MODE_WR   = 8'hA7;
  localparam logic [7:0] MODE_RD   = 8'hE7;
  localparam logic [7:0] STRB_EVEN = 8'h06;
  localparam logic [7:0] STRB_ODD  = 8'h05;

  localparam logic [7:0] LA_ID     = 8'd0;
  localparam logic [7:0] LA_HWVER  = 8'd18;
  localparam logic [7:0] LA_FWVER  = 8'd19;
  localparam logic [7:0] LA_PORTAL = 8'd63;

  typedef struct packed {
    logic [7:0] data;
    logic       err;
    logic       tmo;
  } beat_t;
endpackage

// File: rtl/relay_base_regs.sv
module relay_base_regs
  import relay_xlate_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fire_i,
  input  logic                   is_write_i,
  input  logic [7:0]             addr_i,
  input  logic [7:0]             wdata_i,
  input  logic                   load_lo_i,
  input  logic [7:0]             lo_i,
  output logic [NBYTES-1:0][7:0] base_o,
  output logic                   swallow_o,
  output logic                   zero_o
);
  localparam logic [7:0] FIRST = {2'b00, RG_ADR3};

  assign swallow_o = is_write_i && (addr_i >= FIRST) && (addr_i < FIRST + 8'(NBYTES));

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam logic [7:0] MYADR = FIRST + 8'(NBYTES - 1 - i);
    always_ff @(posedge clk) begin
      if (!rst_n)                                 base_o[i] <= '0;
      else if (fire_i && swallow_o && addr_i == MYADR) base_o[i] <= wdata_i;
      else if (i == 0 && load_lo_i)              base_o[i] <= lo_i;
    end
  end

  always_comb begin
    zero_o = 1'b1;
    for (int i = 1; i < NBYTES; i++)
      if (base_o[i] != 8'h00) zero_o = 1'b0;
  end

  assert_upper_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire_i && swallow_o) |=> $stable(base_o[NBYTES-1:1]));
endmodule

// File: rtl/relay_local_resp.sv
module relay_local_resp
  import relay_xlate_pkg::*;
#(
  parameter logic [7:0] ID_CODE = 8'd87,
  parameter logic [2:0] HW_VER  = 3'd5,
  parameter logic [7:0] FW_VER  = 8'd4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr_i,
  input  logic       zero_i,
  input  logic       clear_i,
  input  logic       take_i,
  output logic       hit_o,
  output logic [7:0] data_o
);
  logic [7:0] ramp_q;
  logic       portal;

  assign portal = zero_i && addr_i == LA_PORTAL;

  always_comb begin
    hit_o  = zero_i;
    data_o = 8'h00;
    unique case (addr_i)
      LA_ID:     data_o = ID_CODE;
      LA_HWVER:  data_o = {5'd0, HW_VER};
      LA_FWVER:  data_o = FW_VER;
      LA_PORTAL: data_o = ramp_q;
      default:   hit_o  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i)     ramp_q <= '0;
    else if (take_i && portal) ramp_q <= ramp_q + 8'd1;
  end

  assert_ramp_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && portal && !clear_i) |=> ramp_q == $past(ramp_q) + 8'd1);
endmodule

// File: rtl/relay_bus_seq.sv
module relay_bus_seq
  import relay_xlate_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1024,
  localparam int TW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            is_read_i,
  input  logic            odd_i,
  input  logic [7:0]      wdata_i,
  input  logic [3:0][7:0] base_i,
  output logic            reg_wr_o,
  output logic            reg_rd_o,
  output logic [5:0]      reg_addr_o,
  output logic [7:0]      reg_wdata_o,
  input  logic [7:0]      reg_rdata_i,
  output logic            done_o,
  output logic [7:0]      rdata_o,
  output logic            berr_o,
  output logic            tmo_o
);
  typedef enum logic [3:0] {
    S_IDLE, S_A3, S_A2, S_A1, S_A0, S_DAT, S_MODE, S_STRB, S_POLL, S_RDAT, S_CLR, S_DONE
  } step_e;

  step_e          step_q;
  logic           rd_q, odd_q;
  logic [7:0]     wd_q;
  logic [TW-1:0]  cnt_q;

  always_comb begin
    reg_wr_o    = 1'b0;
    reg_rd_o    = 1'b0;
    reg_addr_o  = '0;
    reg_wdata_o = '0;
    unique case (step_q)
      S_A3:   begin reg_wr_o = 1'b1; reg_addr_o = RG_ADR3; reg_wdata_o = base_i[3]; end
      S_A2:   begin reg_wr_o = 1'b1; reg_addr_o = RG_ADR2; reg_wdata_o = base_i[2]; end
      S_A1:   begin reg_wr_o = 1'b1; reg_addr_o = RG_ADR1; reg_wdata_o = base_i[1]; end
      S_A0:   begin reg_wr_o = 1'b1; reg_addr_o = RG_ADR0; reg_wdata_o = base_i[0]; end
      S_DAT:  begin reg_wr_o = 1'b1; reg_addr_o = odd_q ? RG_DODD : RG_DEVEN; reg_wdata_o = wd_q; end
      S_MODE: begin reg_wr_o = 1'b1; reg_addr_o = RG_MODE; reg_wdata_o = rd_q ? MODE_RD : MODE_WR; end
      S_STRB: begin reg_wr_o = 1'b1; reg_addr_o = RG_STRB; reg_wdata_o = odd_q ? STRB_ODD : STRB_EVEN; end
      S_POLL: begin reg_rd_o = 1'b1; reg_addr_o = RG_STRB; end
      S_RDAT: begin reg_rd_o = 1'b1; reg_addr_o = odd_q ? RG_DODD : RG_DEVEN; end
      S_CLR:  begin reg_wr_o = 1'b1; reg_addr_o = RG_STRB; reg_wdata_o = 8'h00; end
      default: ;
    endcase
  end

  assign done_o = (step_q == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q  <= S_IDLE;
      rd_q    <= 1'b0;
      odd_q   <= 1'b0;
      wd_q    <= '0;
      cnt_q   <= '0;
      rdata_o <= '0;
      berr_o  <= 1'b0;
      tmo_o   <= 1'b0;
    end else begin
      unique case (step_q)
        S_IDLE: if (start_i) begin
          step_q  <= S_A3;
          rd_q    <= is_read_i;
          odd_q   <= odd_i;
          wd_q    <= wdata_i;
          rdata_o <= '0;
          berr_o  <= 1'b0;
          tmo_o   <= 1'b0;
        end
        S_A3:   step_q <= S_A2;
        S_A2:   step_q <= S_A1;
        S_A1:   step_q <= S_A0;
        S_A0:   step_q <= rd_q ? S_MODE : S_DAT;
        S_DAT:  step_q <= S_MODE;
        S_MODE: step_q <= S_STRB;
        S_STRB: begin step_q <= S_POLL; cnt_q <= '0; end
        S_POLL: begin
          if (reg_rdata_i != 8'h00) begin
            berr_o <= reg_rdata_i[0];
            step_q <= (rd_q && !reg_rdata_i[0]) ? S_RDAT : S_CLR;
          end else if (cnt_q == TW'(TIMEOUT_CYC - 1)) begin
            tmo_o  <= 1'b1;
            step_q <= S_CLR;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_RDAT: begin rdata_o <= reg_rdata_i; step_q <= S_CLR; end
        S_CLR:  step_q <= S_DONE;
        default: step_q <= S_IDLE;
      endcase
    end
  end

  assert_port_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_o && reg_rd_o));
  assert_strobe_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_o && reg_addr_o == RG_STRB) |->
      (reg_wdata_o == 8'h00 || reg_wdata_o == STRB_EVEN || reg_wdata_o == STRB_ODD));
  assert_mode_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_o && reg_addr_o == RG_MODE) |-> (reg_wdata_o == MODE_WR || reg_wdata_o == MODE_RD));
  assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o && reg_addr_o == RG_STRB |-> cnt_q < TW'(TIMEOUT_CYC));
  assert_end_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(berr_o && tmo_o));
endmodule

// File: rtl/relay_cmd_xlate.sv
module relay_cmd_xlate
  import relay_xlate_pkg::*;
#(
  parameter int         LEN_W       = 10,
  parameter int         TIMEOUT_CYC = 1024,
  parameter logic [7:0] ID_CODE     = 8'd87,
  parameter logic [2:0] HW_VER      = 3'd5,
  parameter logic [7:0] FW_VER      = 8'd4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [7:0]       cmd_addr,
  input  logic [7:0]       cmd_data,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_data,
  output logic             rsp_err,
  output logic             rsp_tmo,
  output logic             rsp_last,
  output logic             reg_wr,
  output logic             reg_rd,
  output logic [5:0]       reg_addr,
  output logic [7:0]       reg_wdata,
  input  logic [7:0]       reg_rdata
);
  typedef enum logic [1:0] {T_IDLE, T_BEAT, T_BUS, T_RSP} top_e;

  top_e             st_q;
  logic             rd_q;
  logic [7:0]       addr_q, data_q;
  logic [LEN_W-1:0] left_q;
  beat_t            beat_q;
  logic             last_q;

  logic             fire, swallow, base_zero, loc_hit, seq_done, start;
  logic [3:0][7:0]  base;
  logic [7:0]       loc_data, seq_rdata;
  logic             seq_berr, seq_tmo, beat_local;

  assign cmd_ready  = (st_q == T_IDLE);
  assign rsp_valid  = (st_q == T_RSP);
  assign fire       = cmd_valid && cmd_ready;
  assign beat_local = (st_q == T_BEAT) && rd_q && loc_hit;
  assign start      = (st_q == T_BEAT) && !(rd_q && loc_hit);
  assign rsp_data   = beat_q.data;
  assign rsp_err    = beat_q.err;
  assign rsp_tmo    = beat_q.tmo;
  assign rsp_last   = last_q;

  relay_base_regs #(.NBYTES(4)) u_base (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .is_write_i(cmd_op == OP_WRITE),
    .addr_i(cmd_addr), .wdata_i(cmd_data), .load_lo_i(start), .lo_i(addr_q),
    .base_o(base), .swallow_o(swallow), .zero_o(base_zero)
  );

  relay_local_resp #(.ID_CODE(ID_CODE), .HW_VER(HW_VER), .FW_VER(FW_VER)) u_local (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_q), .zero_i(base_zero),
    .clear_i(fire), .take_i(beat_local), .hit_o(loc_hit), .data_o(loc_data)
  );

  relay_bus_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .is_read_i(rd_q), .odd_i(addr_q[0]),
    .wdata_i(data_q), .base_i(base), .reg_wr_o(reg_wr), .reg_rd_o(reg_rd),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata),
    .done_o(seq_done), .rdata_o(seq_rdata), .berr_o(seq_berr), .tmo_o(seq_tmo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= T_IDLE;
      rd_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      left_q <= '0;
      beat_q <= '0;
      last_q <= 1'b0;
    end else begin
      unique case (st_q)
        T_IDLE: if (fire) begin
          if (swallow) begin
            beat_q <= '0;
            last_q <= 1'b1;
            st_q   <= T_RSP;
          end else begin
            rd_q   <= (cmd_op != OP_WRITE);
            addr_q <= cmd_addr;
            data_q <= cmd_data;
            left_q <= (cmd_op == OP_STREAM) ? cmd_len : '0;
            st_q   <= T_BEAT;
          end
        end
        T_BEAT: begin
          last_q <= (left_q == '0);
          if (beat_local) begin
            beat_q <= '{data: loc_data, err: 1'b0, tmo: 1'b0};
            st_q   <= T_RSP;
          end else begin
            st_q <= T_BUS;
          end
        end
        T_BUS: if (seq_done) begin
          beat_q <= '{data: seq_rdata, err: seq_berr, tmo: seq_tmo};
          st_q   <= T_RSP;
        end
        T_RSP: if (rsp_ready) begin
          if (left_q == '0) st_q <= T_IDLE;
          else begin
            left_q <= left_q - 1'b1;
            st_q   <= T_BEAT;
          end
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  assert_intercept_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && swallow) |=> (!reg_wr && !reg_rd && rsp_valid));
  assert_ready_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && rsp_valid));
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)
                                   && $stable(rsp_tmo) && $stable(rsp_last)));
  assert_local_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_local |=> (!reg_wr && !reg_rd));
endmodule

// File: tb/sim_relay_cmd_xlate.sv
module sim_relay_cmd_xlate;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cmd_valid = 0, cmd_ready, rsp_valid, rsp_ready = 0;
  logic [1:0] cmd_op = 0;
  logic [7:0] cmd_addr = 0, cmd_data = 0, rsp_data;
  logic [9:0] cmd_len = 0;
  logic       rsp_err, rsp_tmo, rsp_last, reg_wr, reg_rd;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  relay_cmd_xlate u0 (.*);

  int checks = 0, fails = 0, cyc = 0, kind = 0;
  int acc_n = 0, log_n = 0;
  logic [5:0] log_a [0:31];
  logic [7:0] log_d [0:31];
  logic [7:0] mdl [0:63];
  logic [7:0] stat_q;
  logic       pend;
  int         dly;

  always @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= 0; pend <= 0; dly <= 0;
    end else begin
      if (reg_wr || reg_rd) acc_n <= acc_n + 1;
      if (reg_wr) begin
        mdl[reg_addr] <= reg_wdata;
        log_a[log_n % 32] <= reg_addr;
        log_d[log_n % 32] <= reg_wdata;
        log_n <= log_n + 1;
        if (reg_addr == 6'd47) begin
          if (reg_wdata != 0) begin pend <= 1; dly <= 3; end
          else begin pend <= 0; stat_q <= 0; end
        end
      end else if (pend) begin
        if (dly == 0) begin
          pend <= 0;
          stat_q <= (kind == 0) ? 8'h02 : (kind == 1) ? 8'h01 : 8'h00;
        end else dly <= dly - 1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      6'd47:   reg_rdata = stat_q;
      6'd50:   reg_rdata = mdl[45] ^ mdl[44] ^ mdl[42] ^ 8'h3C;
      6'd51:   reg_rdata = mdl[45] ^ mdl[43] ^ 8'hC3;
      default: reg_rdata = 8'h00;
    endcase
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                      input logic [9:0] n);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_len = n; cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic take(output logic [7:0] d, output logic e, output logic t, output logic l);
    while (!rsp_valid) @(negedge clk);
    d = rsp_data; e = rsp_err; t = rsp_tmo; l = rsp_last;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  function automatic logic [7:0] bus_val(input logic [7:0] a, input logic [7:0] b3,
                                         input logic [7:0] b2, input logic [7:0] b1);
    return a[0] ? (a ^ b2 ^ 8'hC3) : (a ^ b1 ^ b3 ^ 8'h3C);
  endfunction

  // expected port log of one bus cycle
  task automatic chk_log(input int s, input logic [7:0] a, input logic [7:0] d,
                         input logic [7:0] b3, input logic [7:0] b2, input logic [7:0] b1,
                         input bit rd, input string req);
    logic [5:0] ea [0:7];
    logic [7:0] ed [0:7];
    int n = 0;
    bit ok = 1;
    ea[n] = 42; ed[n] = b3; n++;
    ea[n] = 43; ed[n] = b2; n++;
    ea[n] = 44; ed[n] = b1; n++;
    ea[n] = 45; ed[n] = a;  n++;
    if (!rd) begin ea[n] = a[0] ? 6'd51 : 6'd50; ed[n] = d; n++; end
    ea[n] = 46; ed[n] = rd ? 8'hE7 : 8'hA7; n++;
    ea[n] = 47; ed[n] = a[0] ? 8'h05 : 8'h06; n++;
    ea[n] = 47; ed[n] = 8'h00; n++;
    if (log_n - s != n) ok = 0;
    for (int i = 0; i < n; i++)
      if (log_a[(s + i) % 32] != ea[i] || log_d[(s + i) % 32] != ed[i]) ok = 0;
    chk(ok, req, log_n - s, n);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic e, t, l;
    int s, a0;
    logic [7:0] b3, b2, b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(cmd_ready == 1 && rsp_valid == 0, "R11 reset handshake", {cmd_ready, rsp_valid}, 2);
    chk(reg_wr == 0 && reg_rd == 0, "R11 port idle in reset", {reg_wr, reg_rd}, 0);
    rst_n = 1;
    @(negedge clk);
    send(2'd1, 8'd0, 8'd0, 0); take(d, e, t, l);
    chk(d == 8'd87 && acc_n == 0, "R11 zero base after reset", d, 87);

    // R1 intercept sweep
    b3 = 8'h12; b2 = 8'h00; b1 = 8'h34;
    a0 = acc_n;
    send(2'd0, 8'd42, b3, 0); take(d, e, t, l);
    chk(d == 0 && !e && !t && l, "R1 byte3 beat", {d, e, t, l}, 1);
    send(2'd0, 8'd43, b2, 0); take(d, e, t, l);
    send(2'd0, 8'd44, b1, 0); take(d, e, t, l);
    send(2'd0, 8'd45, 8'h99, 0); take(d, e, t, l);
    repeat (3) @(negedge clk);
    chk(acc_n == a0, "R1 no port access", acc_n, a0);

    // R2/R3 exhaustive writes
    for (int a = 0; a < 256; a++) begin
      if (a >= 42 && a <= 45) continue;
      s = log_n;
      send(2'd0, 8'(a), 8'(a) ^ 8'hA5, 0); take(d, e, t, l);
      chk(!e && !t && l && d == 0, "R5 write ack", {e, t}, 0);
      chk_log(s, 8'(a), 8'(a) ^ 8'hA5, b3, b2, b1, 0, "R2 R3 write sequence");
    end

    // R4 exhaustive reads (nonzero base: no local answers)
    for (int a = 0; a < 256; a++) begin
      s = log_n;
      send(2'd1, 8'(a), 8'h00, 0); take(d, e, t, l);
      chk(d == bus_val(8'(a), b3, b2, b1) && !e, "R4 read data", d, bus_val(8'(a), b3, b2, b1));
      chk_log(s, 8'(a), 0, b3, b2, b1, 1, "R4 read sequence");
    end
    send(2'd3, 8'd7, 8'h00, 0); take(d, e, t, l);
    chk(d == bus_val(8'd7, b3, b2, b1), "R4 op3 read", d, bus_val(8'd7, b3, b2, b1));

    // R5 bus error
    kind = 1;
    s = log_n;
    send(2'd1, 8'd9, 0, 0); take(d, e, t, l);
    chk(e && !t && d == 0, "R5 bus error flag", {d, e, t}, 2);
    chk(log_d[(log_n - 1) % 32] == 0 && log_a[(log_n - 1) % 32] == 47, "R5 strobe clear",
        log_d[(log_n - 1) % 32], 0);

    // R6 timeout
    kind = 2;
    send(2'd0, 8'd8, 8'h11, 0); take(d, e, t, l);
    chk(t && !e && d == 0, "R6 timeout flag", {d, e, t}, 1);
    chk(log_d[(log_n - 1) % 32] == 0 && log_a[(log_n - 1) % 32] == 47, "R6 strobe clear",
        log_d[(log_n - 1) % 32], 0);
    kind = 0;

    // R9 stream over bus
    send(2'd2, 8'd5, 0, 10'd3);
    for (int i = 0; i < 4; i++) begin
      take(d, e, t, l);
      chk(d == bus_val(8'd5, b3, b2, b1) && l == (i == 3), "R9 bus stream beat",
          {d, l}, {bus_val(8'd5, b3, b2, b1), (i == 3)});
    end
    send(2'd1, 8'd0, 0, 0); take(d, e, t, l);
    chk(d == bus_val(8'd0, b3, b2, b1), "R7 no local answer with base set", d,
        bus_val(8'd0, b3, b2, b1));

    // back to zero base
    b3 = 0; b1 = 0;
    send(2'd0, 8'd42, 0, 0); take(d, e, t, l);
    send(2'd0, 8'd44, 0, 0); take(d, e, t, l);

    // R7 identity
    a0 = acc_n;
    send(2'd1, 8'd0, 0, 0);  take(d, e, t, l); chk(d == 87, "R7 id", d, 87);
    send(2'd1, 8'd18, 0, 0); take(d, e, t, l); chk(d == 5, "R7 hw version", d, 5);
    send(2'd1, 8'd19, 0, 0); take(d, e, t, l); chk(d == 4, "R7 fw version", d, 4);
    chk(acc_n == a0, "R7 no port access", acc_n, a0);
    send(2'd1, 8'd1, 0, 0); take(d, e, t, l);
    chk(d == bus_val(8'd1, 0, 0, 0), "R7 other address on bus", d, bus_val(8'd1, 0, 0, 0));

    // R8 ramp with wrap
    a0 = acc_n;
    send(2'd2, 8'd63, 0, 10'd299);
    begin
      int bad = 0;
      for (int i = 0; i < 300; i++) begin
        take(d, e, t, l);
        if (d != 8'(i) || l != (i == 299)) bad++;
      end
      chk(bad == 0, "R8 ramp values and last", bad, 0);
    end
    chk(acc_n == a0, "R8 portal no port access", acc_n, a0);
    send(2'd2, 8'd63, 0, 10'd0); take(d, e, t, l);
    chk(d == 0 && l, "R8 ramp restarts", d, 0);

    // R10 parked beat with command arriving
    send(2'd1, 8'd0, 0, 0);
    while (!rsp_valid) @(negedge clk);
    @(negedge clk);
    cmd_op = 2'd1; cmd_addr = 8'd18; cmd_valid = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == 87 && !cmd_ready, "R10 hold and block",
          {rsp_valid, rsp_data, cmd_ready}, {1'b1, 8'd87, 1'b0});
    end
    take(d, e, t, l);
    chk(d == 87, "R10 parked data", d, 87);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    take(d, e, t, l);
    chk(d == 5, "R10 queued command answered", d, 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule